// File: doc/BRIEF.md
# Per-Channel Calibration Coefficient Bank

This block keeps the offset and gain correction words of a multichannel sigma-delta converter. Each fully differential input channel owns one offset word and one gain word. When the converter runs its inputs as pseudo-differential channels, each neighbouring pair of channels folds onto one shared coefficient pair. The datapath receives the offset and gain for the active conversion channel combinationally.

A host reaches the words through an addressed register port. Each access carries a 4-bit register address and a channel select. Host writes are honoured only while the converter's 3-bit mode field reports idle or power-down. The on-chip calibration engine writes its results straight into the bank, and those results replace whatever the host stored. The bank also keeps the data-ready flag. A fresh sample sets the flag, and only a read of the conversion data address clears it. The bank exposes a fixed read-only identification byte.

Top module: `calcoef_bank`

## Requirements
- R1: After reset every offset word equals mid-scale (bit COEF_W-1 set, all other bits clear: 0x800000 at 24 bits, 0x8000 at 16 bits). Every gain word equals the GAIN_RST parameter. `data_ready` is 0.
- R2: `host_rdata` follows `host_addr` and `host_chan` combinationally. Address 4'b0101 selects the offset bank and address 4'b0110 selects the gain bank. Any other address except 4'b1111 reads 0.
- R3: With `pseudo_mode`=0, channel k (k<5) uses entry k. With `pseudo_mode`=1, channel n (n<10) uses entry n/2, so channels 2m and 2m+1 share entry m. Any other channel number reads 0 and its writes are discarded.
- R4: A host write (`host_wr`=1) to either bank changes nothing unless `conv_mode` is 3'b000 or 3'b001.
- R5: An accepted host write stores `host_wdata` into the addressed word. The new value is visible from the cycle after the write edge.
- R6: A `cal_done` pulse stores `cal_value` into the offset word of the entry that `cal_chan` maps to when `cal_full`=0, or into the gain word when `cal_full`=1. The mode field does not gate it.
- R7: If a calibration result and an accepted host write target the same word in the same cycle, the calibration value is kept. Writes to different words in that cycle both take effect.
- R8: `sample_strobe` sets `data_ready`. A host read (`host_rd`=1) at address 4'b0100 clears it, and a set in the same cycle wins. Host reads of the offset bank, the gain bank or the identification address leave it unchanged.
- R9: Address 4'b1111 reads a byte, zero-extended, whose bits 7:4 are 4'b0100 in the 24-bit build or 4'b0101 in the 16-bit build and whose bits 3:0 are ID_REV. Writes to this address have no effect.
- R10: `act_offset` and `act_gain` show the words of the entry that `act_chan` maps to under the current `pseudo_mode`. They are 0 for an unmapped channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (used for flag clearing) |
| host_addr | input | 4 | Host register address |
| host_chan | input | CHAN_W | Host channel select |
| host_wdata | input | COEF_W | Host write data |
| host_rdata | output | COEF_W | Host read data |
| conv_mode | input | 3 | Converter mode field |
| pseudo_mode | input | 1 | 1 selects pseudo-differential channel folding |
| cal_done | input | 1 | Calibration result valid pulse |
| cal_full | input | 1 | 0 zero-scale (offset), 1 full-scale (gain) |
| cal_chan | input | CHAN_W | Channel being calibrated |
| cal_value | input | COEF_W | Calibration result |
| sample_strobe | input | 1 | New conversion result available |
| act_chan | input | CHAN_W | Active conversion channel |
| act_offset | output | COEF_W | Offset word for the active channel |
| act_gain | output | COEF_W | Gain word for the active channel |
| data_ready | output | 1 | Data-ready flag |

## Verification
Two pairs of functions can meet in one cycle. A host write and a calibration result can land on the same word, and a new sample can arrive while the host reads the data address. The bench drives both strobes on the same clock edge. For the first pair it reads the word back and expects the calibration value. It also sends a host write and a calibration result to two different words in one edge and expects both to stick. For the second pair it expects the flag to stay set.

// File: rtl/calcoef_pkg.sv
package calcoef_pkg;
  localparam logic [3:0] ADDR_DATA   = 4'b0100;
  localparam logic [3:0] ADDR_OFFSET = 4'b0101;
  localparam logic [3:0] ADDR_GAIN   = 4'b0110;
  localparam logic [3:0] ADDR_ID     = 4'b1111;

  // Host writes open only in idle / power-down
  function automatic logic host_write_open(input logic [2:0] mode);
    return (mode == 3'b000) || (mode == 3'b001);
  endfunction

  // Identification byte: upper nibble picks the build width
  function automatic logic [7:0] id_byte(input int width, input logic [3:0] rev);
    return {(width == 16) ? 4'b0101 : 4'b0100, rev};
  endfunction
endpackage

// File: rtl/calcoef_entry_map.sv
module calcoef_entry_map #(
  parameter int CHAN_W  = 4,
  parameter int ENTRIES = 5,
  parameter int IDX_W   = 3
) (
  input  logic [CHAN_W-1:0] chan,
  input  logic              pseudo,
  output logic [IDX_W-1:0]  idx,
  output logic              valid
);
  logic [CHAN_W-1:0] folded;

  always_comb begin
    folded = pseudo ? (chan >> 1) : chan;
    valid  = int'(folded) < ENTRIES;
    idx    = IDX_W'(folded);
  end
endmodule

// File: rtl/calcoef_store.sv
module calcoef_store #(
  parameter int          COEF_W   = 24,
  parameter int          ENTRIES  = 5,
  parameter int          IDX_W    = 3,
  parameter logic [COEF_W-1:0] GAIN_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req_off,
  input  logic              host_req_gain,
  input  logic              mode_open,
  input  logic [IDX_W-1:0]  host_idx,
  input  logic [COEF_W-1:0] host_wdata,
  input  logic              cal_we_off,
  input  logic              cal_we_gain,
  input  logic [IDX_W-1:0]  cal_idx,
  input  logic [COEF_W-1:0] cal_value,
  output logic [COEF_W-1:0] off_q  [ENTRIES],
  output logic [COEF_W-1:0] gain_q [ENTRIES]
);
  localparam logic [COEF_W-1:0] OFF_RST = {1'b1, {(COEF_W-1){1'b0}}};

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    wire host_hit_off  = host_req_off  && (host_idx == IDX_W'(i));
    wire host_hit_gain = host_req_gain && (host_idx == IDX_W'(i));
    wire cal_hit_off   = cal_we_off    && (cal_idx  == IDX_W'(i));
    wire cal_hit_gain  = cal_we_gain   && (cal_idx  == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        off_q[i]  <= OFF_RST;
        gain_q[i] <= GAIN_RST;
      end else begin
        if (cal_hit_off)                   off_q[i]  <= cal_value;
        else if (host_hit_off && mode_open) off_q[i]  <= host_wdata;
        if (cal_hit_gain)                  gain_q[i] <= cal_value;
        else if (host_hit_gain && mode_open) gain_q[i] <= host_wdata;
      end
    end

    // R4
    host_blocked_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_hit_off && !mode_open && !cal_hit_off) |=> $stable(off_q[i]));
    // R4
    host_blocked_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_hit_gain && !mode_open && !cal_hit_gain) |=> $stable(gain_q[i]));
    // R5
    host_take_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_hit_off && mode_open && !cal_hit_off) |=> off_q[i] == $past(host_wdata));
    // R6 R7
    cal_wins_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cal_hit_off |=> off_q[i] == $past(cal_value));
    // R6 R7
    cal_wins_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cal_hit_gain |=> gain_q[i] == $past(cal_value));
  end
endmodule

// File: rtl/calcoef_ready.sv
module calcoef_ready (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic other_rd_i,
  output logic rdy_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     rdy_o <= 1'b0;
    else if (set_i) rdy_o <= 1'b1;
    else if (clr_i) rdy_o <= 1'b0;
  end

  // R8
  coef_read_keeps_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_o && other_rd_i) |=> rdy_o);
  // R8
  data_read_clears_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !rdy_o);
  // R8
  set_wins_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> rdy_o);
endmodule

// File: rtl/calcoef_bank.sv
module calcoef_bank #(
  parameter int                COEF_W   = 24,
  parameter int                ENTRIES  = 5,
  parameter int                CHAN_W   = 4,
  parameter logic [COEF_W-1:0] GAIN_RST = 24'h5A3C95,
  parameter logic [3:0]        ID_REV   = 4'h3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [3:0]        host_addr,
  input  logic [CHAN_W-1:0] host_chan,
  input  logic [COEF_W-1:0] host_wdata,
  output logic [COEF_W-1:0] host_rdata,
  input  logic [2:0]        conv_mode,
  input  logic              pseudo_mode,
  input  logic              cal_done,
  input  logic              cal_full,
  input  logic [CHAN_W-1:0] cal_chan,
  input  logic [COEF_W-1:0] cal_value,
  input  logic              sample_strobe,
  input  logic [CHAN_W-1:0] act_chan,
  output logic [COEF_W-1:0] act_offset,
  output logic [COEF_W-1:0] act_gain,
  output logic              data_ready
);
  import calcoef_pkg::*;

  localparam int         IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [7:0] ID_BYTE = id_byte(COEF_W, ID_REV);

  logic [IDX_W-1:0]  host_idx, cal_idx, act_idx;
  logic              host_ok, cal_ok, act_ok;
  logic [COEF_W-1:0] off_q  [ENTRIES];
  logic [COEF_W-1:0] gain_q [ENTRIES];

  calcoef_entry_map #(.CHAN_W(CHAN_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_map_host (
    .chan(host_chan), .pseudo(pseudo_mode), .idx(host_idx), .valid(host_ok));
  calcoef_entry_map #(.CHAN_W(CHAN_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_map_cal (
    .chan(cal_chan), .pseudo(pseudo_mode), .idx(cal_idx), .valid(cal_ok));
  calcoef_entry_map #(.CHAN_W(CHAN_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_map_act (
    .chan(act_chan), .pseudo(pseudo_mode), .idx(act_idx), .valid(act_ok));

  // Named events for the store and the assertions
  wire host_req_off  = host_wr && host_ok && (host_addr == ADDR_OFFSET);
  wire host_req_gain = host_wr && host_ok && (host_addr == ADDR_GAIN);
  wire mode_open     = host_write_open(conv_mode);
  wire cal_we_off    = cal_done && cal_ok && !cal_full;
  wire cal_we_gain   = cal_done && cal_ok &&  cal_full;
  wire data_rd       = host_rd && (host_addr == ADDR_DATA);
  wire other_rd      = host_rd && ((host_addr == ADDR_OFFSET) ||
                                   (host_addr == ADDR_GAIN) || (host_addr == ADDR_ID));

  calcoef_store #(.COEF_W(COEF_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W), .GAIN_RST(GAIN_RST)) u_store (
    .clk(clk), .rst_n(rst_n),
    .host_req_off(host_req_off), .host_req_gain(host_req_gain), .mode_open(mode_open),
    .host_idx(host_idx), .host_wdata(host_wdata),
    .cal_we_off(cal_we_off), .cal_we_gain(cal_we_gain), .cal_idx(cal_idx), .cal_value(cal_value),
    .off_q(off_q), .gain_q(gain_q));

  calcoef_ready u_ready (
    .clk(clk), .rst_n(rst_n), .set_i(sample_strobe), .clr_i(data_rd),
    .other_rd_i(other_rd), .rdy_o(data_ready));

  always_comb begin
    host_rdata = '0;
    unique case (host_addr)
      ADDR_OFFSET: if (host_ok) host_rdata = off_q[host_idx];
      ADDR_GAIN:   if (host_ok) host_rdata = gain_q[host_idx];
      ADDR_ID:     host_rdata = {{(COEF_W-8){1'b0}}, ID_BYTE};
      default:     host_rdata = '0;
    endcase
  end

  always_comb begin
    act_offset = act_ok ? off_q[act_idx]  : '0;
    act_gain   = act_ok ? gain_q[act_idx] : '0;
  end

  // R3 R10
  unmapped_act_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !act_ok |-> (act_offset == '0 && act_gain == '0));
endmodule

// File: tb/calcoef_bank_test.sv
`timescale 1ns/1ps
module calcoef_bank_test;
  localparam int W = 24;
  localparam logic [W-1:0] GRST = 24'h5A3C95;
  localparam logic [3:0] A_DATA = 4'b0100, A_OFF = 4'b0101, A_GAIN = 4'b0110, A_ID = 4'b1111;

  logic clk = 0, rst_n = 0;
  logic host_wr = 0, host_rd = 0, pseudo_mode = 0, cal_done = 0, cal_full = 0, sample_strobe = 0;
  logic [3:0] host_addr = 0, host_chan = 0, cal_chan = 0, act_chan = 0;
  logic [2:0] conv_mode = 0;
  logic [W-1:0] host_wdata = 0, cal_value = 0;
  logic [W-1:0] host_rdata, act_offset, act_gain;
  logic data_ready;

  int total = 0, failed = 0;
  logic [W-1:0] m_off [5];
  logic [W-1:0] m_gain [5];

  always #5 clk = ~clk;

  calcoef_bank #(.GAIN_RST(GRST)) uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_chan(host_chan), .host_wdata(host_wdata), .host_rdata(host_rdata), .conv_mode(conv_mode),
    .pseudo_mode(pseudo_mode), .cal_done(cal_done), .cal_full(cal_full), .cal_chan(cal_chan),
    .cal_value(cal_value), .sample_strobe(sample_strobe), .act_chan(act_chan),
    .act_offset(act_offset), .act_gain(act_gain), .data_ready(data_ready));

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bench-side channel mapping: returns -1 when unmapped
  function automatic int entry_of(input int ch, input logic ps);
    int e = ps ? ch / 2 : ch;
    return (e < 5) ? e : -1;
  endfunction

  task automatic rd(input logic [3:0] a, input logic [3:0] ch, input string tag, input logic [W-1:0] exp);
    @(negedge clk); host_addr = a; host_chan = ch; #1;
    chk(tag, host_rdata, exp);
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] ch, input logic [W-1:0] d);
    int e;
    @(negedge clk); host_wr = 1; host_addr = a; host_chan = ch; host_wdata = d;
    @(negedge clk); host_wr = 0;
    e = entry_of(ch, pseudo_mode);
    if (e >= 0 && conv_mode <= 3'b001) begin
      if (a == A_OFF) m_off[e] = d;
      if (a == A_GAIN) m_gain[e] = d;
    end
  endtask

  task automatic cal(input logic full, input logic [3:0] ch, input logic [W-1:0] d);
    int e;
    @(negedge clk); cal_done = 1; cal_full = full; cal_chan = ch; cal_value = d;
    @(negedge clk); cal_done = 0;
    e = entry_of(ch, pseudo_mode);
    if (e >= 0) begin
      if (full) m_gain[e] = d; else m_off[e] = d;
    end
  endtask

  task automatic check_all(input string tag);
    for (int k = 0; k < 5; k++) begin
      rd(A_OFF, 4'(k), tag, m_off[k]);
      rd(A_GAIN, 4'(k), tag, m_gain[k]);
    end
  endtask

  task automatic t_reset();
    for (int k = 0; k < 5; k++) begin m_off[k] = 24'h800000; m_gain[k] = GRST; end
    check_all("R1 reset words");
    chk("R1 reset ready", {23'd0, data_ready}, 24'd0);
    rd(4'b0011, 4'd0, "R2 unknown address reads 0", 24'd0);
  endtask

  task automatic t_modes();
    for (int m = 0; m < 8; m++) begin
      conv_mode = 3'(m);
      wr(A_OFF, 4'd1, 24'h100000 + 24'(m));
      rd(A_OFF, 4'd1, $sformatf("R4 R5 offset write mode %0d", m), m_off[1]);
      wr(A_GAIN, 4'd4, 24'h200000 + 24'(m));
      rd(A_GAIN, 4'd4, $sformatf("R4 R5 gain write mode %0d", m), m_gain[4]);
    end
    check_all("R4 other entries untouched");
  endtask

  task automatic t_cal();
    conv_mode = 3'b100;
    cal(1'b0, 4'd2, 24'h0ABCDE);
    rd(A_OFF, 4'd2, "R6 zero-scale to offset", 24'h0ABCDE);
    cal(1'b1, 4'd2, 24'h654321);
    rd(A_GAIN, 4'd2, "R6 full-scale to gain", 24'h654321);
    check_all("R6 calibration scope");
  endtask

  task automatic t_collide();
    conv_mode = 3'b000;
    @(negedge clk);
    host_wr = 1; host_addr = A_OFF; host_chan = 4'd3; host_wdata = 24'h111111;
    cal_done = 1; cal_full = 0; cal_chan = 4'd3; cal_value = 24'h222222;
    @(negedge clk); host_wr = 0; cal_done = 0;
    m_off[3] = 24'h222222;
    rd(A_OFF, 4'd3, "R7 calibration wins collision", 24'h222222);
    @(negedge clk);
    host_wr = 1; host_addr = A_GAIN; host_chan = 4'd0; host_wdata = 24'h333333;
    cal_done = 1; cal_full = 1; cal_chan = 4'd4; cal_value = 24'h444444;
    @(negedge clk); host_wr = 0; cal_done = 0;
    m_gain[0] = 24'h333333; m_gain[4] = 24'h444444;
    check_all("R7 distinct targets both land");
  endtask

  task automatic t_pseudo();
    pseudo_mode = 1; conv_mode = 3'b001;
    wr(A_OFF, 4'd7, 24'h777777);
    rd(A_OFF, 4'd6, "R3 pseudo pair shares entry", 24'h777777);
    cal(1'b1, 4'd9, 24'h999999);
    rd(A_GAIN, 4'd8, "R3 pseudo cal chan 9 -> entry 4", 24'h999999);
    wr(A_OFF, 4'd10, 24'hDEAD00);
    rd(A_OFF, 4'd10, "R3 unmapped pseudo chan reads 0", 24'd0);
    pseudo_mode = 0;
    check_all("R3 pseudo writes seen in full mode");
    wr(A_GAIN, 4'd5, 24'hBEEF00);
    rd(A_GAIN, 4'd5, "R3 unmapped full chan reads 0", 24'd0);
    check_all("R3 unmapped write discarded");
  endtask

  task automatic t_active();
    for (int c = 0; c < 12; c++) begin
      for (int p = 0; p < 2; p++) begin
        int e;
        @(negedge clk); pseudo_mode = p[0]; act_chan = 4'(c); #1;
        e = entry_of(c, p[0]);
        chk($sformatf("R10 act offset ch%0d ps%0d", c, p), act_offset, (e >= 0) ? m_off[e] : 24'd0);
        chk($sformatf("R10 act gain ch%0d ps%0d", c, p), act_gain, (e >= 0) ? m_gain[e] : 24'd0);
      end
    end
    pseudo_mode = 0;
  endtask

  task automatic t_ready();
    @(negedge clk); sample_strobe = 1;
    @(negedge clk); sample_strobe = 0;
    chk("R8 strobe sets ready", {23'd0, data_ready}, 24'd1);
    @(negedge clk); host_rd = 1; host_addr = A_OFF;
    @(negedge clk); host_addr = A_GAIN;
    @(negedge clk); host_addr = A_ID;
    @(negedge clk); host_rd = 0;
    chk("R8 bank/ID reads keep ready", {23'd0, data_ready}, 24'd1);
    @(negedge clk); host_rd = 1; host_addr = A_DATA;
    @(negedge clk); host_rd = 0;
    chk("R8 data read clears ready", {23'd0, data_ready}, 24'd0);
    @(negedge clk); host_rd = 1; host_addr = A_DATA; sample_strobe = 1;
    @(negedge clk); host_rd = 0; sample_strobe = 0;
    chk("R8 set wins over clear", {23'd0, data_ready}, 24'd1);
  endtask

  task automatic t_id();
    rd(A_ID, 4'd0, "R9 ID byte", 24'h000043);
    conv_mode = 3'b000;
    wr(A_ID, 4'd0, 24'hFFFFFF);
    rd(A_ID, 4'd0, "R9 ID write ignored", 24'h000043);
    check_all("R9 ID write touches no bank");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_modes();
    t_cal();
    t_collide();
    t_pseudo();
    t_active();
    t_ready();
    t_id();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    #2000000;
    total++; failed++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule